// File: doc/BRIEF.md
# Chip-Select Timing Controller

This block drives the active-low chip-select lines of an SPI host and spaces them around each transfer by delays counted in input clock cycles. The transfer sequencer offers a start with `start_valid`; the block accepts it when `start_ready` is high, pulls the chosen chip-select line low, waits the programmed setup delay and then raises `sclk_go`, which allows serial clocking to begin. When the sequencer reports the final clock edge with `xfer_end`, the block drops `sclk_go` and counts three windows at once from that edge: the release delay until chip select goes high, a hold window during which `data_hold` tells the shifter to keep the last data steady, and the minimum deasserted gap before a new start can be taken.

The start handshake is valid/ready: a start is taken on a rising edge where both are high. The sequencer may hold `start_valid` high for as long as it likes; while `start_ready` is low the request waits, and nothing happens on the chip-select lines. `start_ready` is also the "idle again" signal after a transfer that closes. The four delays come from one 32-bit timing word and are read live, so the word must stay stable from the start request until `start_ready` returns.

Top module: `cs_timing_ctrl`

## Requirements
- R1: While reset is low, and after it, until a start is taken, every `cs_n` line is high, `sclk_go` and `data_hold` are low and `start_ready` is high.
- R2: At most one `cs_n` line is low at any time, and it is the line whose index equals the `cs_pick` value sampled when the start was taken (`cs_pick` = 0 picks `cs_n[0]`, 1 picks `cs_n[1]`).
- R3: The chip-select line falls in the cycle after the start is taken; `sclk_go` rises exactly D0 cycles later, where D0 = `timing_cfg[3:0]` (with D0 = 0, both change on the same edge).
- R4: `xfer_end` taken while `sclk_go` is high makes `sclk_go` fall on that same edge.
- R5: The chip-select line rises exactly D1 cycles after the edge that takes `xfer_end`, where D1 = `timing_cfg[11:8]`.
- R6: `data_hold` is high for exactly D2 cycles starting at the edge that takes `xfer_end`, where D2 = `timing_cfg[19:16]`.
- R7: `start_ready` returns max(D1 + D3, D2) cycles after the edge that takes `xfer_end`, where D3 = `timing_cfg[27:24]`, so chip select stays high for at least D3 cycles before it can fall again.
- R8: A start request held high while `start_ready` is low leaves every output unchanged and is taken on the first edge after `start_ready` rises.
- R9: `xfer_end` while `sclk_go` is low has no effect on any output.
- R10: A change of `cs_pick` after a start is taken does not move the active chip select to another line.
- R11: Only bits [3:0], [11:8], [19:16] and [27:24] of `timing_cfg` affect the block; all other bits are ignored.
- R12: A delay value of 0 adds no cycles; the sequence still passes each phase in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all delays count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_cfg | input | 32 | Timing word holding the four 4-bit delays |
| cs_pick | input | 1 | Index of the chip-select line for the next transfer |
| start_valid | input | 1 | Start request from the sequencer |
| start_ready | output | 1 | Start may be taken; also marks the end of the idle gap |
| sclk_go | output | 1 | Serial clocking may run |
| xfer_end | input | 1 | Final clock edge has passed; close the transfer |
| data_hold | output | 1 | Keep the last output data steady |
| cs_n | output | 2 | Active-low chip-select lines |

## Verification
Every output is a function of registers only, so each result is due a fixed number of edges after its stimulus: chip select on the edge that takes the start, `sclk_go` D0 edges later, and chip-select release, end of hold and return of ready at D1, D2 and max(D1 + D3, D2) edges after the edge that takes `xfer_end`. The driver works out these edge numbers when it issues a transfer and queues one expected snapshot of all outputs for every cycle until ready returns; the monitor samples just after the falling edge and compares the snapshot tagged with the current edge count, so an output that moves one cycle early or late fails. Back-to-back starts issued inside the gap, stray end pulses during setup and a `cs_pick` flip mid-transfer are included in those traces.

// File: rtl/cs_timing_pkg.sv
package cs_timing_pkg;

  localparam int DLY_W = 4;

  typedef struct packed {
    logic [DLY_W-1:0] gap;
    logic [DLY_W-1:0] keep;
    logic [DLY_W-1:0] lag;
    logic [DLY_W-1:0] lead;
  } delays_t;

  // Field positions are fixed by the register word the sequencer writes.
  function automatic delays_t split_timing(input logic [31:0] word);
    delays_t d;
    d.lead = word[3:0];
    d.lag  = word[11:8];
    d.keep = word[19:16];
    d.gap  = word[27:24];
    return d;
  endfunction

endpackage

// File: rtl/cstc_down_counter.sv
module cstc_down_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero_o
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero_o = (cnt == '0);

  // R7: an expired window stays expired until it is loaded again
  a_r7_zero_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o && !load |=> zero_o);

endmodule

// File: rtl/cstc_cs_decode.sv
module cstc_cs_decode #(
  parameter int NUM_CS = 2,
  parameter int SEL_W  = 1
) (
  input  logic              en,
  input  logic [SEL_W-1:0]  sel,
  output logic [NUM_CS-1:0] cs_n
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_line
    assign cs_n[g] = ~(en && (sel == SEL_W'(g)));
  end

endmodule

// File: rtl/cs_timing_ctrl.sv
module cs_timing_ctrl
  import cs_timing_pkg::*;
#(
  parameter int NUM_CS = 2,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       timing_cfg,
  input  logic [SEL_W-1:0]  cs_pick,
  input  logic              start_valid,
  output logic              start_ready,
  output logic              sclk_go,
  input  logic              xfer_end,
  output logic              data_hold,
  output logic [NUM_CS-1:0] cs_n
);

  localparam int GAP_W = DLY_W + 1;

  delays_t          dly;
  logic             accept, finish;
  logic             active_q;
  logic [SEL_W-1:0] sel_q;
  logic             lead_zero, lag_zero, keep_zero, gap_zero;
  logic [GAP_W-1:0] gap_total;
  logic             cs_en;
  logic             unused_cfg_bits;

  assign dly = split_timing(timing_cfg);
  assign unused_cfg_bits = ^{timing_cfg[31:28], timing_cfg[23:20],
                             timing_cfg[15:12], timing_cfg[7:4]};

  assign accept = start_valid && start_ready;
  assign finish = xfer_end && sclk_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sel_q    <= '0;
    end else if (accept) begin
      active_q <= 1'b1;
      sel_q    <= cs_pick;
    end else if (finish) begin
      active_q <= 1'b0;
    end
  end

  // Gap is measured from chip-select release, so it runs for lag + gap.
  assign gap_total = GAP_W'(dly.lag) + GAP_W'(dly.gap);

  cstc_down_counter #(.W(DLY_W)) u_lead (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(dly.lead),
    .zero_o(lead_zero));

  cstc_down_counter #(.W(DLY_W)) u_lag (
    .clk(clk), .rst_n(rst_n), .load(finish), .load_val(dly.lag),
    .zero_o(lag_zero));

  cstc_down_counter #(.W(DLY_W)) u_keep (
    .clk(clk), .rst_n(rst_n), .load(finish), .load_val(dly.keep),
    .zero_o(keep_zero));

  cstc_down_counter #(.W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(finish), .load_val(gap_total),
    .zero_o(gap_zero));

  assign sclk_go     = active_q && lead_zero;
  assign cs_en       = active_q || !lag_zero;
  assign data_hold   = !keep_zero;
  assign start_ready = !active_q && lag_zero && keep_zero && gap_zero;

  cstc_cs_decode #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_dec (
    .en(cs_en), .sel(sel_q), .cs_n(cs_n));

  // R2: never more than one line active
  a_r2_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  // R3: clocking is only allowed under an active chip select
  a_r3_go_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_go |-> !(&cs_n));

  // R4: closing the transfer stops clocking at once
  a_r4_go_drops: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_go && xfer_end |=> !sclk_go);

  // R6: the hold window never overlaps clocking
  a_r6_hold_no_go: assert property (@(posedge clk) disable iff (!rst_n)
    data_hold |-> !sclk_go);

  // R7: ready only in a fully quiet state
  a_r7_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> ((&cs_n) && !sclk_go && !data_hold));

  // R8: a chip select can only fall after a taken start
  a_r8_fall_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(&cs_n) |-> $past(start_valid && start_ready));

  // R10: the active line does not move during a transfer
  a_r10_line_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cs_n) && $past(!(&cs_n)) |-> $stable(cs_n));

endmodule

// File: tb/cs_timing_ctrl_bench.sv
`timescale 1ns/1ps
module cs_timing_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] timing_cfg = '0;
  logic        cs_pick = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic        sclk_go;
  logic        xfer_end = 1'b0;
  logic        data_hold;
  logic [1:0]  cs_n;

  always #2 clk = ~clk;

  cs_timing_ctrl u_cs_timing_ctrl (
    .clk(clk), .rst_n(rst_n), .timing_cfg(timing_cfg), .cs_pick(cs_pick),
    .start_valid(start_valid), .start_ready(start_ready), .sclk_go(sclk_go),
    .xfer_end(xfer_end), .data_hold(data_hold), .cs_n(cs_n));

  typedef struct {
    int         c;
    logic [1:0] cs;
    logic       go;
    logic       hold;
    logic       rdy;
    string      tag;
  } snap_t;

  snap_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int rdy_cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Monitor: compares the snapshot due at this edge count
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0 && q[0].c < cyc) begin
        void'(q.pop_front());
        chk("R2 R3 missed snapshot", 0, 1);
      end
      if (q.size() > 0 && q[0].c == cyc) begin
        snap_t e;
        e = q.pop_front();
        chk({"R2 R5 R10 cs_n ", e.tag}, int'(cs_n), int'(e.cs));
        chk({"R3 R4 R9 sclk_go ", e.tag}, int'(sclk_go), int'(e.go));
        chk({"R6 data_hold ", e.tag}, int'(data_hold), int'(e.hold));
        chk({"R7 R8 start_ready ", e.tag}, int'(start_ready), int'(e.rdy));
      end
    end
  end

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Driver: computes the whole expected trace, then plays the handshake
  task automatic xfer(input int sel, input int f0, input int f1, input int f2,
                      input int f3, input int run, input bit early,
                      input bit stray, input bit flip, input logic [31:0] junk,
                      input string tag);
    int e0, x, t;
    logic [31:0] w;
    w = junk;
    w[3:0] = f0[3:0];
    w[11:8] = f1[3:0];
    w[19:16] = f2[3:0];
    w[27:24] = f3[3:0];
    timing_cfg = w;
    cs_pick = sel[0];
    start_valid = 1'b1;
    if (cyc > rdy_cyc)
      q.push_back('{c: cyc, cs: 2'b11, go: 1'b0, hold: 1'b0, rdy: 1'b1, tag: tag});
    e0 = imax(cyc + 1, rdy_cyc + 1);
    x = e0 + f0 + 1 + run;
    t = imax(f1 + f3, f2);
    for (int c = e0; c <= x + t; c++) begin
      snap_t s;
      s.c = c;
      s.cs = 2'b11;
      if (c < x + f1) s.cs[sel] = 1'b0;
      s.go = (c < x) && (c >= e0 + f0);
      s.hold = (c >= x) && (c < x + f2);
      s.rdy = (c >= x + t);
      s.tag = tag;
      q.push_back(s);
    end
    rdy_cyc = x + t;
    while (cyc < e0) @(negedge clk);
    start_valid = 1'b0;
    if (flip) cs_pick = ~sel[0];          // R10: ignored mid-transfer
    if (stray) begin                      // R9: end while sclk_go low
      xfer_end = 1'b1;
      @(negedge clk);
      xfer_end = 1'b0;
    end
    while (cyc < x - 1) @(negedge clk);
    xfer_end = 1'b1;
    @(negedge clk);
    xfer_end = 1'b0;
    if (early) begin
      while (cyc < x + f1) @(negedge clk);
    end else begin
      while (cyc < x + t) @(negedge clk);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1: state under reset
    chk("R1 cs_n in reset", int'(cs_n), 3);
    chk("R1 sclk_go in reset", int'(sclk_go), 0);
    chk("R1 data_hold in reset", int'(data_hold), 0);
    chk("R1 start_ready in reset", int'(start_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cs_n after reset", int'(cs_n), 3);
    rdy_cyc = cyc - 1;
    // R3 R5 basic sequence on line 0
    xfer(0, 3, 2, 1, 4, 2, 1'b0, 1'b0, 1'b0, 32'h0, "R3 R5 basic");
    // R12 all delays zero on line 1
    xfer(1, 0, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0, 32'h0, "R12 zero");
    // R6 hold dominates, R9 stray end, R10 pick flip
    xfer(0, 2, 1, 6, 1, 1, 1'b0, 1'b1, 1'b1, 32'h0, "R6 R9 R10");
    // R11 junk bits, maximum delays, next start issued inside the gap
    xfer(1, 15, 15, 15, 15, 3, 1'b1, 1'b0, 1'b0, 32'hF0F0F0F0, "R11 max");
    // R8 start waits for the gap of the previous transfer
    xfer(0, 1, 3, 0, 9, 0, 1'b0, 1'b0, 1'b1, 32'h0, "R8 held");
    repeat (3) @(negedge clk);
    chk("R7 snapshots drained", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule